// File: doc/BRIEF.md
# Interconnect Port Profiling Counters With Timeout

This block sits beside one request/acknowledge port of an on-chip interconnect. It only watches the port. Each cycle it samples the request, request-acknowledge, read data-acknowledge, write data-acknowledge and write-after-read stall signals. From these it keeps five saturating event counters. Software reads and clears the counters through a small register port.

The block also has a timeout detector. It measures how long a request has been waiting without an acknowledge. When that wait reaches a programmable number of cycles, it sets a sticky status bit. No interrupt is raised. Software must poll the bit and clear it by writing a one to it.

Register map, with a 3-bit word address and a 32-bit data path:
- Address 0 is control. Bit 0 is the enable. Writing 1 to bit 1 clears all counters.
- Address 1 is the timeout threshold.
- Address 2 is status. Bit 0 is the timeout flag.
- Addresses 3 to 7 are the counters.

Reads are combinational. Counter values are zero-extended to 32 bits.

Top module: `ic_prof_unit`

## Requirements
- R1: The counter at address 3 increments by one on each rising clock edge where `mon_wr_dack` is 1 and the unit is enabled.
- R2: The counter at address 4 increments by one on each rising clock edge where `mon_rd_dack` is 1 and the unit is enabled.
- R3: When `mon_rd_dack` and `mon_wr_dack` are both 1 in the same cycle, the counters at addresses 3 and 4 each increment by one.
- R4: The counter at address 5 increments in each enabled cycle where `mon_req` and `mon_req_ack` are both 1.
- R5: The counter at address 6 increments in each enabled cycle where `mon_war_stall` is 1.
- R6: The counter at address 7 increments in each enabled cycle where `mon_req` is 1 and `mon_req_ack` is 0.
- R7: Bit 0 of address 0 is the enable. While it is 0, no counter changes and the timeout flag is never set.
- R8: Writing a word with bit 1 set to address 0 zeroes all five counters on that edge. The clear takes priority over any event in the same cycle.
- R9: Each counter is `CNT_W` bits wide (default 32) and saturates at its all-ones value.
- R10: Bit 0 of address 2 is set after `mon_req`=1 and `mon_req_ack`=0 has held for N consecutive enabled cycles. N is the value at address 1. Any other cycle restarts the run. A threshold of 0 never sets the flag.
- R11: The timeout flag is sticky and is cleared by writing a 1 to bit 0 of address 2. If the flag is set and cleared in the same cycle, the set wins.
- R12: After reset, all counters read 0, and the enable, the threshold and the timeout flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_req | input | 1 | Monitored request |
| mon_req_ack | input | 1 | Monitored request acknowledge |
| mon_rd_dack | input | 1 | Monitored read data acknowledge |
| mon_wr_dack | input | 1 | Monitored write data acknowledge |
| mon_war_stall | input | 1 | Write-after-read stall indication |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |

## Verification
Two situations are the hardest to reach from the ports.

The first is a register write that lands in the same cycle as the event it competes with. This covers a counter clear during a live data acknowledge, and a status clear while the timeout keeps firing. The stimulus holds the monitored signal high across the write, so that both act on one edge.

The second is saturation. The bench reduces `CNT_W` to 8 and drives more than 255 acknowledges, so that the saturation limit is reached in a few hundred cycles.

// File: rtl/prof_pkg.sv
package prof_pkg;

  localparam int NUM_EV = 5;

  // event indices; each also selects its counter address (index + 3)
  localparam int EV_WR_DACK = 0;
  localparam int EV_RD_DACK = 1;
  localparam int EV_ACCEPT  = 2;
  localparam int EV_STALL   = 3;
  localparam int EV_WAIT    = 4;

  typedef enum logic [2:0] {
    RA_CTRL   = 3'd0,
    RA_THRESH = 3'd1,
    RA_STATUS = 3'd2,
    RA_CNT0   = 3'd3
  } reg_addr_e;

  // saturating increment against a given ceiling
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] ceil);
    return (v >= ceil) ? ceil : v + 32'd1;
  endfunction

  // timeout reached when the run including this cycle meets a nonzero threshold
  function automatic logic run_reached(input logic [31:0] run_so_far, input logic [31:0] thr);
    return (thr != 32'd0) && ((run_so_far + 32'd1) >= thr);
  endfunction

endpackage

// File: rtl/prof_event_decode.sv
module prof_event_decode
  import prof_pkg::*;
(
  input  logic              en,
  input  logic              req,
  input  logic              req_ack,
  input  logic              rd_dack,
  input  logic              wr_dack,
  input  logic              war_stall,
  output logic [NUM_EV-1:0] ev,
  output logic              pending
);

  logic [NUM_EV-1:0] raw_ev;

  always_comb begin
    raw_ev             = '0;
    raw_ev[EV_WR_DACK] = wr_dack;
    raw_ev[EV_RD_DACK] = rd_dack;
    raw_ev[EV_ACCEPT]  = req & req_ack;
    raw_ev[EV_STALL]   = war_stall;
    raw_ev[EV_WAIT]    = req & ~req_ack;
  end

  assign ev      = en ? raw_ev : '0;
  assign pending = en & req & ~req_ack;

endmodule

// File: rtl/prof_counter.sv
module prof_counter
  import prof_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [31:0] cnt_next;

  assign cnt_next = sat_inc(32'(cnt), 32'(CNT_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt_next[W-1:0];
  end

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt));

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/prof_timeout.sv
module prof_timeout
  import prof_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending,
  input  logic [TMO_W-1:0] thresh,
  input  logic             flag_w1c,
  output logic             flag
);

  localparam logic [TMO_W-1:0] RUN_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] run_q;
  logic [31:0]      run_next;
  logic             hit;

  assign run_next = sat_inc(32'(run_q), 32'(RUN_MAX));
  assign hit      = pending && run_reached(32'(run_q), 32'(thresh));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (pending) run_q <= run_next[TMO_W-1:0];
    else              run_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (flag_w1c) flag <= 1'b0;
  end

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_w1c) |=> flag);

  assert_set_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(pending));

  assert_thr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh == '0 && !flag) |=> !flag);

  assert_run_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> (run_q == '0));

endmodule

// File: rtl/ic_prof_unit.sv
module ic_prof_unit
  import prof_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int TMO_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mon_req,
  input  logic        mon_req_ack,
  input  logic        mon_rd_dack,
  input  logic        mon_wr_dack,
  input  logic        mon_war_stall,
  input  logic        cfg_wr,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata
);

  logic              enable_q;
  logic [TMO_W-1:0]  thresh_q;
  logic              clr_cmd;
  logic              flag_w1c;
  logic              tmo_flag;
  logic [NUM_EV-1:0] ev;
  logic              pending;
  logic [CNT_W-1:0]  cnt_q [NUM_EV];

  // register write decode
  assign clr_cmd  = cfg_wr && (cfg_addr == RA_CTRL)   && cfg_wdata[1];
  assign flag_w1c = cfg_wr && (cfg_addr == RA_STATUS) && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      thresh_q <= '0;
    end else if (cfg_wr) begin
      if (cfg_addr == RA_CTRL)   enable_q <= cfg_wdata[0];
      if (cfg_addr == RA_THRESH) thresh_q <= cfg_wdata[TMO_W-1:0];
    end
  end

  prof_event_decode u_decode (
    .en        (enable_q),
    .req       (mon_req),
    .req_ack   (mon_req_ack),
    .rd_dack   (mon_rd_dack),
    .wr_dack   (mon_wr_dack),
    .war_stall (mon_war_stall),
    .ev        (ev),
    .pending   (pending)
  );

  for (genvar gi = 0; gi < NUM_EV; gi++) begin : g_cnt
    prof_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_cmd),
      .inc   (ev[gi]),
      .cnt   (cnt_q[gi])
    );
  end

  prof_timeout #(.TMO_W(TMO_W)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .pending  (pending),
    .thresh   (thresh_q),
    .flag_w1c (flag_w1c),
    .flag     (tmo_flag)
  );

  // combinational read mux
  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RA_CTRL:   cfg_rdata = {31'd0, enable_q};
      RA_THRESH: cfg_rdata = 32'(thresh_q);
      RA_STATUS: cfg_rdata = {31'd0, tmo_flag};
      default:   cfg_rdata = 32'(cnt_q[int'(cfg_addr) - int'(RA_CNT0)]);
    endcase
  end

  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_q |-> (ev == '0 && !pending));

  assert_dual_dack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q && mon_rd_dack && mon_wr_dack) |-> (ev[EV_RD_DACK] && ev[EV_WR_DACK]));

  assert_accept_wait_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev[EV_ACCEPT] && ev[EV_WAIT]));

endmodule

// File: tb/ic_prof_unit_bench.sv
`timescale 1ns/1ps
module ic_prof_unit_bench;

  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mon_req = 0, mon_req_ack = 0, mon_rd_dack = 0, mon_wr_dack = 0, mon_war_stall = 0;
  logic        cfg_wr = 0;
  logic [2:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ic_prof_unit #(.CNT_W(CW), .TMO_W(16)) u_ic_prof_unit (
    .clk, .rst_n, .mon_req, .mon_req_ack, .mon_rd_dack, .mon_wr_dack,
    .mon_war_stall, .cfg_wr, .cfg_addr, .cfg_wdata, .cfg_rdata
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] d;
    reg_read(a, d);
    check(req, d, exp);
  endtask

  task automatic idle_bus();
    mon_req = 0; mon_req_ack = 0; mon_rd_dack = 0; mon_wr_dack = 0; mon_war_stall = 0;
  endtask

  task automatic drive(input int cycles, input logic rq, input logic ak,
                       input logic rd, input logic wr, input logic st);
    @(negedge clk);
    mon_req = rq; mon_req_ack = ak; mon_rd_dack = rd; mon_wr_dack = wr; mon_war_stall = st;
    repeat (cycles) @(negedge clk);
    idle_bus();
  endtask

  task automatic clear_enable();
    reg_write(3'd0, 32'h3);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) expect_reg("R12 reset state", 3'(a), 32'd0);
  endtask

  task automatic t_dacks();
    clear_enable();
    drive(5, 0, 0, 0, 1, 0);
    expect_reg("R1 write dack count", 3'd3, 32'd5);
    drive(3, 0, 0, 1, 0, 0);
    expect_reg("R2 read dack count", 3'd4, 32'd3);
    drive(4, 0, 0, 1, 1, 0);
    expect_reg("R3 dual dack write", 3'd3, 32'd9);
    expect_reg("R3 dual dack read", 3'd4, 32'd7);
  endtask

  task automatic t_handshake();
    clear_enable();
    drive(6, 1, 1, 0, 0, 0);
    expect_reg("R4 accepted count", 3'd5, 32'd6);
    expect_reg("R6 no wait during accept", 3'd7, 32'd0);
    drive(4, 1, 0, 0, 0, 0);
    expect_reg("R6 wait count", 3'd7, 32'd4);
    expect_reg("R4 no accept while waiting", 3'd5, 32'd6);
    expect_reg("R10 threshold zero never flags", 3'd2, 32'd0);
    drive(7, 0, 0, 0, 0, 1);
    expect_reg("R5 stall count", 3'd6, 32'd7);
  endtask

  task automatic t_disable();
    clear_enable();
    reg_write(3'd1, 32'd1);
    reg_write(3'd0, 32'h0);
    drive(5, 1, 0, 1, 1, 1);
    for (int a = 3; a < 8; a++) expect_reg("R7 disabled counters frozen", 3'(a), 32'd0);
    expect_reg("R7 disabled no timeout", 3'd2, 32'd0);
    reg_write(3'd1, 32'd0);
    reg_write(3'd0, 32'h1);
  endtask

  task automatic t_clear_priority();
    clear_enable();
    drive(3, 0, 0, 0, 1, 0);
    expect_reg("R8 pre-clear count", 3'd3, 32'd3);
    @(negedge clk);
    mon_wr_dack = 1;
    cfg_wr = 1; cfg_addr = 3'd0; cfg_wdata = 32'h3;
    @(negedge clk);
    cfg_wr = 0; mon_wr_dack = 0;
    expect_reg("R8 clear wins over event", 3'd3, 32'd0);
  endtask

  task automatic t_saturate();
    clear_enable();
    drive(300, 0, 0, 0, 1, 0);
    expect_reg("R9 saturate at max", 3'd3, 32'd255);
    drive(2, 0, 0, 0, 1, 0);
    expect_reg("R9 hold at max", 3'd3, 32'd255);
  endtask

  task automatic t_timeout();
    clear_enable();
    reg_write(3'd1, 32'd3);
    expect_reg("R10 threshold readback", 3'd1, 32'd3);
    drive(2, 1, 0, 0, 0, 0);
    expect_reg("R10 below threshold", 3'd2, 32'd0);
    drive(2, 1, 0, 0, 0, 0);
    expect_reg("R10 run restarts", 3'd2, 32'd0);
    drive(3, 1, 0, 0, 0, 0);
    expect_reg("R10 threshold reached", 3'd2, 32'd1);
    repeat (3) @(negedge clk);
    expect_reg("R11 sticky", 3'd2, 32'd1);
    reg_write(3'd2, 32'd1);
    expect_reg("R11 write-one clears", 3'd2, 32'd0);
    @(negedge clk);
    mon_req = 1;
    repeat (4) @(negedge clk);
    cfg_wr = 1; cfg_addr = 3'd2; cfg_wdata = 32'd1;
    @(negedge clk);
    cfg_wr = 0;
    idle_bus();
    expect_reg("R11 set wins over clear", 3'd2, 32'd1);
    reg_write(3'd2, 32'd1);
    expect_reg("R11 clear after set", 3'd2, 32'd0);
  endtask

  initial begin
    idle_bus();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_dacks();
    t_handshake();
    t_disable();
    t_clear_priority();
    t_saturate();
    t_timeout();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule